// File: doc/BRIEF.md
# Strobe-Driven Microcontroller Shared-RAM Bridge

This block sits between a small microcontroller's two 8-bit parallel ports and the host side of a system. The host side has a byte-wide shared RAM, two player input ports and a vectored interrupt request. Port A carries both addresses and data. Each bus operation is made by toggling single bits of port B. A rising edge on one bit latches an address. A falling edge on another bit starts a read or a write; bit 4 of the same write picks which. A falling edge on a third bit copies the read result into port A's input register. A rising edge on bit 5 raises a host interrupt whose vector is the byte in RAM location 0. Each port has a direction register. Reading a port returns output-register bits where the direction bit is 1 and input bits where it is 0.

The host owns a two-bit run-control register. One bit releases the sound processor from reset. The other releases the microcontroller, and while it is 0 every microcontroller-side register in the bridge is held cleared.

Two state machines do the sequencing. The access sequencer has the states ACC_IDLE, ACC_READ and ACC_WRITE. From any state, an accepted start strobe moves it to ACC_READ or ACC_WRITE, and every other cycle returns it to ACC_IDLE. The RAM or input-port access happens on the edge that leaves ACC_READ or ACC_WRITE. The interrupt machine has the states IRQ_IDLE and IRQ_PENDING. It moves from IRQ_IDLE to IRQ_PENDING on the interrupt strobe. It moves from IRQ_PENDING back to IRQ_IDLE on `irq_ack`, unless a new strobe arrives in the same cycle. A strobe arriving while pending reloads the vector.

Top module: `mcu_ram_bridge`

## Requirements
- R1: `mcu_rdata` is selected combinationally by `mcu_sel`: 0 gives port A `(a_out & dir_a) | (a_in & ~dir_a)`, 1 gives port B `(b_out & dir_b) | (pb_in & ~dir_b)`, 2 gives dir_a and 3 gives dir_b. A write with `mcu_wr` high loads the register that `mcu_sel` selects at the clock edge.
- R2: A port B strobe on bit n is found by comparing the written value with the previous port B output, and only when dir_b[n] is 1. With dir_b[n] at 0, toggling bit n has no effect.
- R3: A falling edge of port B bit 0 copies the data latch, as it stood before that edge, into the port A input register.
- R4: A rising edge of port B bit 1 captures the port A output register as the 8-bit access address.
- R5: A falling edge of port B bit 3 with the new bit 4 at 0 enters ACC_WRITE. On the next edge, RAM[address[6:0]] takes the port A output value captured at the strobe. An address with bit 7 set writes nothing.
- R6: A falling edge of port B bit 3 with the new bit 4 at 1 enters ACC_READ. On the next edge, for an address below 0x80, the latch loads RAM[address[6:0]].
- R7: In ACC_READ with address bit 7 set, the latch loads `p2_in` when address bit 0 is 1 and `p1_in` when it is 0. The input is sampled on the edge that leaves ACC_READ.
- R8: A rising edge of port B bit 5 sets `irq_req` at that edge, with `irq_vec` equal to RAM[0] as it was before the edge. `irq_req` and `irq_vec` hold until an `irq_ack` is sampled in a cycle without a new strobe.
- R9: A falling edge of port B bit 6 or bit 7 drives `odd_strobe` high for exactly the one cycle after the write and changes nothing else.
- R10: `ctl_we` loads `snd_run` from `ctl_wdata[2]` and `mcu_run` from `ctl_wdata[1]`. Both are 0 after reset, which holds both processors in reset.
- R11: Reset clears the port, direction, address, latch and input registers, both state machines and the RAM. While `mcu_run` is 0, the microcontroller-side registers and the access sequencer are cleared from the following edge, and microcontroller writes are ignored.
- R12: `host_we` writes RAM[`host_addr`] at the clock edge, and `host_rdata` shows RAM[`host_addr`] combinationally. If the host and the microcontroller write the same location at the same edge, the microcontroller's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Host write strobe for the run-control register |
| ctl_wdata | input | 2 | Run-control data, bits [2:1] |
| snd_run | output | 1 | Sound processor released from reset when 1 |
| mcu_run | output | 1 | Microcontroller released from reset when 1 |
| mcu_wr | input | 1 | Microcontroller register write |
| mcu_sel | input | 2 | Register select: 0 A data, 1 B data, 2 A direction, 3 B direction |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Selected register readback |
| pb_in | input | 8 | External levels on port B pins |
| p1_in | input | 8 | Player 1 input port |
| p2_in | input | 8 | Player 2 input port |
| host_we | input | 1 | Host RAM write |
| host_addr | input | 7 | Host RAM address |
| host_wdata | input | 8 | Host RAM write data |
| host_rdata | output | 8 | Host RAM read data |
| irq_req | output | 1 | Interrupt request to host |
| irq_ack | input | 1 | Host interrupt acknowledge |
| irq_vec | output | 8 | Interrupt vector |
| odd_strobe | output | 1 | One-cycle flag for a bit 6 or bit 7 falling edge |

## Verification
Port writes, the address capture, the input-register copy, the interrupt request and the odd-strobe flag all appear on the edge that samples the microcontroller write. A RAM write or latch load appears one edge later, when the access sequencer leaves ACC_READ or ACC_WRITE. A read result therefore needs one idle cycle before the strobe that copies it into port A. The bench drives inputs just after each rising edge. Its behavioural model advances on the same edges, and every output is compared at the falling edge. The directed checks wait exactly one idle cycle for register effects and two for RAM effects before they sample.

// File: rtl/mcu_bridge_pkg.sv
package mcu_bridge_pkg;

    // microcontroller register select
    typedef enum logic [1:0] {
        SEL_A_DATA = 2'd0,
        SEL_B_DATA = 2'd1,
        SEL_A_DIR  = 2'd2,
        SEL_B_DIR  = 2'd3
    } port_sel_e;

    // port B strobe bit roles
    localparam int PB_FETCH  = 0;
    localparam int PB_ADDR   = 1;
    localparam int PB_GO     = 3;
    localparam int PB_RW     = 4;
    localparam int PB_IRQ    = 5;
    localparam int PB_ODD_LO = 6;
    localparam int PB_ODD_HI = 7;

    // host run-control bit positions
    localparam int CTL_MCU_RUN = 1;
    localparam int CTL_SND_RUN = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_e;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

endpackage

// File: rtl/mcu_port_regs.sv
module mcu_port_regs
    import mcu_bridge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pb_in,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] a_out,
    output logic              fetch,
    output logic              addr_ld,
    output logic              go,
    output logic              go_read,
    output logic              irq_raise,
    output logic              odd_q
);

    logic [DATA_W-1:0] a_out_q, b_out_q, dir_a_q, dir_b_q;
    logic              wr_b;
    logic              odd_d;

    assign wr_b = wr && !hold && (port_sel_e'(sel) == SEL_B_DATA);

    // strobes: direction-qualified edges against the previous output value
    assign fetch     = wr_b & dir_b_q[PB_FETCH] & ~wdata[PB_FETCH] &  b_out_q[PB_FETCH];
    assign addr_ld   = wr_b & dir_b_q[PB_ADDR]  &  wdata[PB_ADDR]  & ~b_out_q[PB_ADDR];
    assign go        = wr_b & dir_b_q[PB_GO]    & ~wdata[PB_GO]    &  b_out_q[PB_GO];
    assign go_read   = wdata[PB_RW];
    assign irq_raise = wr_b & dir_b_q[PB_IRQ]   &  wdata[PB_IRQ]   & ~b_out_q[PB_IRQ];
    assign odd_d     = wr_b & ((dir_b_q[PB_ODD_LO] & ~wdata[PB_ODD_LO] & b_out_q[PB_ODD_LO])
                             | (dir_b_q[PB_ODD_HI] & ~wdata[PB_ODD_HI] & b_out_q[PB_ODD_HI]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_out_q <= '0;
            b_out_q <= '0;
            dir_a_q <= '0;
            dir_b_q <= '0;
            odd_q   <= 1'b0;
        end else if (hold) begin
            a_out_q <= '0;
            b_out_q <= '0;
            dir_a_q <= '0;
            dir_b_q <= '0;
            odd_q   <= 1'b0;
        end else begin
            odd_q <= odd_d;
            if (wr) begin
                unique case (port_sel_e'(sel))
                    SEL_A_DATA: a_out_q <= wdata;
                    SEL_B_DATA: b_out_q <= wdata;
                    SEL_A_DIR:  dir_a_q <= wdata;
                    SEL_B_DIR:  dir_b_q <= wdata;
                endcase
            end
        end
    end

    always_comb begin
        unique case (port_sel_e'(sel))
            SEL_A_DATA: rdata = (a_out_q & dir_a_q) | (a_in  & ~dir_a_q);
            SEL_B_DATA: rdata = (b_out_q & dir_b_q) | (pb_in & ~dir_b_q);
            SEL_A_DIR:  rdata = dir_a_q;
            SEL_B_DIR:  rdata = dir_b_q;
        endcase
    end

    assign a_out = a_out_q;

    // R11: holding the microcontroller in reset empties its registers
    p_held_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (dir_a_q == '0 && dir_b_q == '0 && b_out_q == '0 && !odd_q));

endmodule

// File: rtl/bridge_access_fsm.sv
module bridge_access_fsm
    import mcu_bridge_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              fetch,
    input  logic              addr_ld,
    input  logic              go,
    input  logic              go_read,
    input  logic [DATA_W-1:0] a_out,
    input  logic [DATA_W-1:0] p1_in,
    input  logic [DATA_W-1:0] p2_in,
    input  logic              host_we,
    input  logic [RAM_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] ram_word0
);

    localparam int DEPTH  = 1 << RAM_AW;
    localparam int IO_BIT = DATA_W - 1;

    acc_state_e        st_q, st_d;
    logic [DATA_W-1:0] addr_q, wdat_q, latch_q, a_in_q;
    logic [DATA_W-1:0] ram [DEPTH];
    logic [DATA_W-1:0] ram_rd, rd_val;

    assign ram_rd = ram[addr_q[RAM_AW-1:0]];
    assign rd_val = addr_q[IO_BIT] ? (addr_q[0] ? p2_in : p1_in) : ram_rd;

    // next state
    always_comb begin
        st_d = ACC_IDLE;
        if (go) st_d = go_read ? ACC_READ : ACC_WRITE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st_q <= ACC_IDLE;
        else if (hold) st_q <= ACC_IDLE;
        else           st_q <= st_d;
    end

    // datapath and RAM (MCU write placed last so it wins a collision)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdat_q  <= '0;
            latch_q <= '0;
            a_in_q  <= '0;
            for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
        end else begin
            if (host_we) ram[host_addr] <= host_wdata;
            if (hold) begin
                addr_q  <= '0;
                wdat_q  <= '0;
                latch_q <= '0;
                a_in_q  <= '0;
            end else begin
                if (addr_ld) addr_q <= a_out;
                if (go)      wdat_q <= a_out;
                if (fetch)   a_in_q <= latch_q;
                unique case (st_q)
                    ACC_READ:  latch_q <= rd_val;
                    ACC_WRITE: if (!addr_q[IO_BIT]) ram[addr_q[RAM_AW-1:0]] <= wdat_q;
                    default:   ;
                endcase
            end
        end
    end

    assign host_rdata = ram[host_addr];
    assign a_in       = a_in_q;
    assign ram_word0  = ram[0];

    // R4: address strobe captures port A output
    p_addr_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ld && !hold) |=> addr_q == $past(a_out));

    // R5: a write step stores the captured data
    p_ram_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ACC_WRITE && !addr_q[IO_BIT] && !hold)
            |=> ram[$past(addr_q[RAM_AW-1:0])] == $past(wdat_q));

    // R6: a RAM read step loads the latch
    p_read_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ACC_READ && !addr_q[IO_BIT] && !hold) |=> latch_q == $past(ram_rd));

endmodule

// File: rtl/bridge_irq_fsm.sv
module bridge_irq_fsm
    import mcu_bridge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise,
    input  logic              ack,
    input  logic [DATA_W-1:0] vec_src,
    output logic              irq_req,
    output logic [DATA_W-1:0] irq_vec
);

    irq_state_e        st_q, st_d;
    logic [DATA_W-1:0] vec_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE:    if (raise) st_d = IRQ_PENDING;
            IRQ_PENDING: if (!raise && ack) st_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vec_q <= '0;
        else if (raise) vec_q <= vec_src;
    end

    assign irq_req = (st_q == IRQ_PENDING);
    assign irq_vec = vec_q;

    // R8: a strobe always leaves the request raised
    p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> irq_req);

    // R8: request and vector hold until acknowledged
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack && !raise) |=> (irq_req && $stable(irq_vec)));

endmodule

// File: rtl/mcu_ram_bridge.sv
module mcu_ram_bridge
    import mcu_bridge_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [2:1]        ctl_wdata,
    output logic              snd_run,
    output logic              mcu_run,
    input  logic              mcu_wr,
    input  logic [1:0]        mcu_sel,
    input  logic [DATA_W-1:0] mcu_wdata,
    output logic [DATA_W-1:0] mcu_rdata,
    input  logic [DATA_W-1:0] pb_in,
    input  logic [DATA_W-1:0] p1_in,
    input  logic [DATA_W-1:0] p2_in,
    input  logic              host_we,
    input  logic [RAM_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_req,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] irq_vec,
    output logic              odd_strobe
);

    logic              snd_run_q, mcu_run_q, mcu_hold;
    logic              fetch, addr_ld, go, go_read, irq_raise;
    logic [DATA_W-1:0] a_out, a_in, ram_word0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snd_run_q <= 1'b0;
            mcu_run_q <= 1'b0;
        end else if (ctl_we) begin
            snd_run_q <= ctl_wdata[CTL_SND_RUN];
            mcu_run_q <= ctl_wdata[CTL_MCU_RUN];
        end
    end

    assign snd_run  = snd_run_q;
    assign mcu_run  = mcu_run_q;
    assign mcu_hold = !mcu_run_q;

    mcu_port_regs #(.DATA_W(DATA_W)) u_ports (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (mcu_hold),
        .wr        (mcu_wr),
        .sel       (mcu_sel),
        .wdata     (mcu_wdata),
        .pb_in     (pb_in),
        .a_in      (a_in),
        .rdata     (mcu_rdata),
        .a_out     (a_out),
        .fetch     (fetch),
        .addr_ld   (addr_ld),
        .go        (go),
        .go_read   (go_read),
        .irq_raise (irq_raise),
        .odd_q     (odd_strobe)
    );

    bridge_access_fsm #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (mcu_hold),
        .fetch      (fetch),
        .addr_ld    (addr_ld),
        .go         (go),
        .go_read    (go_read),
        .a_out      (a_out),
        .p1_in      (p1_in),
        .p2_in      (p2_in),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .a_in       (a_in),
        .ram_word0  (ram_word0)
    );

    bridge_irq_fsm #(.DATA_W(DATA_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (irq_raise),
        .ack     (irq_ack),
        .vec_src (ram_word0),
        .irq_req (irq_req),
        .irq_vec (irq_vec)
    );

    // R10: the control write reaches the run outputs one edge later
    p_ctl_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (mcu_run == $past(ctl_wdata[CTL_MCU_RUN]) &&
                    snd_run == $past(ctl_wdata[CTL_SND_RUN])));

endmodule

// File: tb/mcu_ram_bridge_tb.sv
module mcu_ram_bridge_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [2:1] ctl_wdata = '0;
    logic       snd_run, mcu_run;
    logic       mcu_wr = 1'b0;
    logic [1:0] mcu_sel = '0;
    logic [7:0] mcu_wdata = '0;
    logic [7:0] mcu_rdata;
    logic [7:0] pb_in = 8'hC3;
    logic [7:0] p1_in = 8'h91;
    logic [7:0] p2_in = 8'h6E;
    logic       host_we = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_req;
    logic       irq_ack = 1'b0;
    logic [7:0] irq_vec;
    logic       odd_strobe;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mcu_ram_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .snd_run(snd_run), .mcu_run(mcu_run), .mcu_wr(mcu_wr), .mcu_sel(mcu_sel),
        .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata), .pb_in(pb_in), .p1_in(p1_in),
        .p2_in(p2_in), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec),
        .odd_strobe(odd_strobe)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_ram [128];
    logic [7:0] m_aout, m_bout, m_dira, m_dirb, m_ain, m_addr, m_wdat, m_latch, m_vec;
    int         m_acc;  // 0 idle, 1 read, 2 write
    bit         m_pend, m_odd, m_snd, m_run;

    initial begin
        foreach (m_ram[i]) m_ram[i] = '0;
        {m_aout, m_bout, m_dira, m_dirb, m_ain, m_addr, m_wdat, m_latch, m_vec} = '0;
        m_acc = 0; m_pend = 0; m_odd = 0; m_snd = 0; m_run = 0;
    end

    always @(posedge clk) begin : model_step
        logic [7:0] rise, fall, rdv, o_addr, o_latch, o_aout, o_wdat, o_ram0;
        int         o_acc;
        bit         o_run;
        if (!rst_n) begin
            foreach (m_ram[i]) m_ram[i] = '0;
            {m_aout, m_bout, m_dira, m_dirb, m_ain, m_addr, m_wdat, m_latch, m_vec} = '0;
            m_acc = 0; m_pend = 0; m_odd = 0; m_snd = 0; m_run = 0;
        end else begin
            o_run = m_run; o_addr = m_addr; o_latch = m_latch; o_aout = m_aout;
            o_wdat = m_wdat; o_ram0 = m_ram[0]; o_acc = m_acc;
            rdv = o_addr[7] ? (o_addr[0] ? p2_in : p1_in) : m_ram[o_addr[6:0]];
            rise = '0; fall = '0;
            if (o_run && mcu_wr && mcu_sel == 2'd1) begin
                rise = m_dirb & mcu_wdata & ~m_bout;
                fall = m_dirb & ~mcu_wdata & m_bout;
            end
            if (ctl_we) begin m_snd = ctl_wdata[2]; m_run = ctl_wdata[1]; end
            if (host_we) m_ram[host_addr] = host_wdata;
            if (rise[5]) begin m_pend = 1; m_vec = o_ram0; end
            else if (irq_ack) m_pend = 0;
            if (!o_run) begin
                {m_aout, m_bout, m_dira, m_dirb, m_ain, m_addr, m_wdat, m_latch} = '0;
                m_acc = 0; m_odd = 0;
            end else begin
                if (o_acc == 2 && !o_addr[7]) m_ram[o_addr[6:0]] = o_wdat;
                if (o_acc == 1) m_latch = rdv;
                if (fall[0]) m_ain = o_latch;
                if (rise[1]) m_addr = o_aout;
                if (fall[3]) begin m_wdat = o_aout; m_acc = mcu_wdata[4] ? 1 : 2; end
                else m_acc = 0;
                m_odd = fall[6] | fall[7];
                if (mcu_wr) begin
                    case (mcu_sel)
                        2'd0: m_aout = mcu_wdata;
                        2'd1: m_bout = mcu_wdata;
                        2'd2: m_dira = mcu_wdata;
                        default: m_dirb = mcu_wdata;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_rdata(input logic [1:0] s);
        case (s)
            2'd0: return (m_aout & m_dira) | (m_ain & ~m_dira);
            2'd1: return (m_bout & m_dirb) | (pb_in & ~m_dirb);
            2'd2: return m_dira;
            default: return m_dirb;
        endcase
    endfunction

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R1 mcu_rdata vs model", mcu_rdata, model_rdata(mcu_sel));
            chk("R12 host_rdata vs model", host_rdata, m_ram[host_addr]);
            chk("R8 irq_req vs model", {7'd0, irq_req}, {7'd0, m_pend});
            chk("R8 irq_vec vs model", irq_vec, m_vec);
            chk("R9 odd_strobe vs model", {7'd0, odd_strobe}, {7'd0, m_odd});
            chk("R10 run outputs vs model", {6'd0, snd_run, mcu_run}, {6'd0, m_snd, m_run});
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic nop();
        @(posedge clk); #2;
        mcu_wr = 0; ctl_we = 0; host_we = 0; irq_ack = 0;
    endtask

    task automatic mw(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #2;
        ctl_we = 0; host_we = 0; irq_ack = 0;
        mcu_wr = 1; mcu_sel = s; mcu_wdata = d;
    endtask

    task automatic ctl(input logic [2:1] d);
        @(posedge clk); #2;
        mcu_wr = 0; host_we = 0; irq_ack = 0;
        ctl_we = 1; ctl_wdata = d;
    endtask

    task automatic hw(input logic [6:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        mcu_wr = 0; ctl_we = 0; irq_ack = 0;
        host_we = 1; host_addr = a; host_wdata = d;
    endtask

    task automatic ack();
        @(posedge clk); #2;
        mcu_wr = 0; ctl_we = 0; host_we = 0;
        irq_ack = 1;
    endtask

    task automatic see(input logic [1:0] s, input string tag, input logic [7:0] exp);
        mcu_sel = s; #1;
        chk(tag, mcu_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R11 reset state
        for (int s = 0; s < 4; s++) begin
            mcu_sel = s[1:0]; #1;
            chk("R11 reset readback", mcu_rdata, (s == 1) ? pb_in : 8'h00);
        end
        chk("R10 reset run bits", {6'd0, snd_run, mcu_run}, 8'h00);
        chk("R11 reset irq", {7'd0, irq_req}, 8'h00);
        cmp_en = 1'b1;

        ctl(2'b11); nop();
        chk("R10 run released", {6'd0, snd_run, mcu_run}, 8'h03);

        mw(3, 8'hFF); mw(2, 8'hFF); mw(1, 8'h09);
        // write 0xA7 to address 5
        mw(0, 8'h05); mw(1, 8'h0B); mw(0, 8'hA7); mw(1, 8'h03); nop(); nop();
        host_addr = 7'd5; #1;
        chk("R5 ram write", host_rdata, 8'hA7);
        // read it back into the latch and fetch it into port A
        mw(1, 8'h0B); mw(1, 8'h13); nop(); mw(1, 8'h12); mw(2, 8'h00); nop();
        see(0, "R3 R6 fetched read data", 8'hA7);
        // mixed direction on port A
        mw(0, 8'h5A); mw(2, 8'hF0); nop();
        see(0, "R1 mixed port A", 8'h57);
        mw(2, 8'h00);
        // input port select, player 2
        mw(0, 8'h81); mw(1, 8'h10); mw(1, 8'h1A); mw(1, 8'h12); nop();
        mw(1, 8'h13); mw(1, 8'h12); nop();
        see(0, "R7 R4 player 2 input", 8'h6E);
        // player 1
        mw(0, 8'h80); mw(1, 8'h10); mw(1, 8'h1A); mw(1, 8'h12); nop();
        mw(1, 8'h13); mw(1, 8'h12); nop();
        see(0, "R7 player 1 input", 8'h91);
        // strobes ignored without direction
        p1_in = 8'h33;
        mw(3, 8'h00); mw(1, 8'h1A); mw(1, 8'h12); nop();
        see(1, "R1 port B input bits", 8'hC3);
        mw(3, 8'hFF); mw(1, 8'h13); mw(1, 8'h12); nop();
        see(0, "R2 gated strobe no read", 8'h91);
        // interrupt
        hw(7'd0, 8'h3C); mw(1, 8'h32); nop();
        chk("R8 irq raised", {7'd0, irq_req}, 8'h01);
        chk("R8 irq vector", irq_vec, 8'h3C);
        nop(); nop();
        chk("R8 irq held", {7'd0, irq_req}, 8'h01);
        ack(); nop();
        chk("R8 irq cleared", {7'd0, irq_req}, 8'h00);
        // unexpected edges on bits 6 and 7
        mw(1, 8'hF2); mw(1, 8'h32); nop();
        chk("R9 odd flag", {7'd0, odd_strobe}, 8'h01);
        see(0, "R9 no side effect", 8'h91);
        nop();
        chk("R9 odd flag one cycle", {7'd0, odd_strobe}, 8'h00);
        chk("R9 no irq", {7'd0, irq_req}, 8'h00);
        // microcontroller held in reset
        ctl(2'b10); nop(); nop();
        chk("R10 run bits", {6'd0, snd_run, mcu_run}, 8'h02);
        see(3, "R11 dir cleared", 8'h00);
        mw(3, 8'hFF); nop();
        see(3, "R11 write ignored", 8'h00);
        see(0, "R11 port A cleared", 8'h00);
        // host RAM port
        hw(7'h7F, 8'h55); nop();
        host_addr = 7'h7F; #1;
        chk("R12 host write", host_rdata, 8'h55);

        // randomised phase, compared every clock against the model
        ctl(2'b11); nop();
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #2;
            mcu_wr    = $urandom_range(0, 1);
            mcu_sel   = 2'($urandom_range(0, 3));
            mcu_wdata = 8'($urandom);
            host_we   = ($urandom_range(0, 7) == 0);
            host_addr = 7'($urandom);
            host_wdata = 8'($urandom);
            irq_ack   = ($urandom_range(0, 5) == 0);
            ctl_we    = ($urandom_range(0, 99) == 0);
            ctl_wdata = {1'b1, ($urandom_range(0, 3) != 0)};
            if ($urandom_range(0, 15) == 0) begin
                p1_in = 8'($urandom); p2_in = 8'($urandom); pb_in = 8'($urandom);
            end
        end
        nop(); nop();
        finish_run();
    end

endmodule